// File: doc/BRIEF.md
# MDIO Management Command Engine

This block is the management-bus master of an Ethernet MAC. Software first writes a target register with the PHY register number, the port address and the device address. It then writes a command register that holds 16 bits of data, a two-bit command code and a busy bit. Setting the busy bit together with a valid code starts a transaction. The engine then produces the management clock `mdc` and shifts the frame out on the data line. For a read it releases the line and collects the 16 bits that the PHY returns. When the transaction ends, the busy bit clears itself. After a read the data field holds the returned value.

A mode register holds one bit per low-numbered port. A set bit selects Clause 22 framing for that port. Every other port uses Clause 45 framing, where each access is an address frame followed by a read or write frame. The register port is a plain select/write-enable bus with a combinational read path.

Control is a four-state machine. The states are IDLE, LOAD, SHIFT and DONE:
- IDLE→LOAD on a start pulse.
- LOAD→SHIFT unconditionally, after the 64-slot frame image is loaded.
- SHIFT→LOAD at the last falling MDC edge of a Clause 45 address frame.
- SHIFT→DONE at the last falling edge of any other frame.
- DONE→IDLE unconditionally, while busy is cleared and read data is written back.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset the target, command and mode registers read 0, `mdc` is low, `mdio_oe` is low and `mdio_out` is 1.
- R2: The target register (select 0) holds the register number in bits [15:0], the port address in [20:16] and the device address in [25:21]; bits [31:26] read 0.
- R3: The command register (select 1) holds data in [15:0], the code in [17:16] and busy in bit 31. A write stores data and code. Busy is set and a transaction starts only if bit 31 is written as 1 and the code is 1 (write) or 3 (read); codes 0 and 2 leave busy at 0 and produce no MDC activity.
- R4: Busy reads 1 from the cycle after the starting write until the transaction ends, then clears without any software action.
- R5: A command-register write while busy is 1 is ignored: the data and code fields keep their values and no extra frame is sent.
- R6: The mode register (select 2) keeps only bits [NUM_C22-1:0]; higher written bits read 0. A port p uses Clause 22 only if p < NUM_C22 and mode bit p is set; all other ports use Clause 45.
- R7: A Clause 22 frame is 32 ones, start 01, opcode 01 (write) or 10 (read), 5-bit port, register number bits [4:0], turnaround 10, then 16 data bits, MSB first.
- R8: A Clause 45 access is an address frame (32 ones, 00, opcode 00, port, device, 10, 16-bit register number) followed by a second frame with opcode 01 (write, carrying the data) or 11 (read).
- R9: In a read frame `mdio_oe` drops after the 14 bits that follow the preamble. The 16 bits on `mdio_in` at the rising MDC edges of frame slots 48..63 (MSB first) become the data field.
- R10: MDC has a period of 2×MDC_HALF system clocks and stays low when idle. `mdio_out` changes only when MDC falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 target, 1 command, 2 mode |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_in | input | 1 | Management data from the pad |
| mdio_out | output | 1 | Management data to the pad |
| mdio_oe | output | 1 | Pad output enable |

## Verification
The bench builds the block with MDC_HALF = 2, so a Clause 45 read takes about 520 system clocks and several dozen mixed transactions fit easily in the run. It uses NUM_C22 = 4 and draws port numbers from 0 to 7. Random mode bytes therefore hit both sides of the Clause 22 limit, including ports whose mode bit is set but which must still use Clause 45. A PHY model in the bench records every driven bit at each rising MDC edge and returns random read data on falling edges. The bench compares the recorded frames and the returned data field with values that its own functions compute.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int REG_W           = 32;
    localparam int DATA_W          = 16;
    localparam int ADR_W           = 5;
    localparam int FRAME_SLOTS     = 64;
    localparam int SLOT_W          = $clog2(FRAME_SLOTS);
    localparam int RD_RELEASE_SLOT = 46;
    localparam int RD_DATA_SLOT    = 48;

    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_CMD  = 2'd1;
    localparam logic [1:0] SEL_MODE = 2'd2;

    localparam logic [1:0] CODE_WR = 2'd1;
    localparam logic [1:0] CODE_RD = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SHIFT,
        ST_DONE
    } eng_state_e;

    typedef struct packed {
        logic [ADR_W-1:0]  dev;
        logic [ADR_W-1:0]  port;
        logic [DATA_W-1:0] regnum;
    } target_t;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int MDC_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise,
    output logic fall
);
    localparam int CW = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;

    logic [CW-1:0] cnt_q;
    logic          mdc_q;
    logic          wrap;

    assign wrap = (cnt_q == CW'(MDC_HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign mdc  = mdc_q;
    assign rise = run && wrap && !mdc_q;
    assign fall = run && wrap && mdc_q;

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int NUM_C22 = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wen,
    input  logic [1:0]           sel,
    input  logic [REG_W-1:0]     wdata,
    input  logic                 done,
    input  logic                 done_rd,
    input  logic [DATA_W-1:0]    rd_data,
    output logic [REG_W-1:0]     rdata,
    output logic                 busy,
    output logic                 start,
    output target_t              tgt,
    output logic [DATA_W-1:0]    cmd_data,
    output logic [1:0]           cmd_code,
    output logic [NUM_C22-1:0]   mode
);
    logic code_ok;

    assign code_ok = (wdata[17:16] == CODE_WR) || (wdata[17:16] == CODE_RD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt      <= '0;
            cmd_data <= '0;
            cmd_code <= '0;
            mode     <= '0;
            busy     <= 1'b0;
            start    <= 1'b0;
        end else begin
            start <= 1'b0;
            if (wen && sel == SEL_ADDR) begin
                tgt <= wdata[3*ADR_W+DATA_W-ADR_W-1:0];
            end
            if (wen && sel == SEL_MODE) begin
                mode <= wdata[NUM_C22-1:0];
            end
            if (wen && sel == SEL_CMD && !busy) begin
                cmd_data <= wdata[DATA_W-1:0];
                cmd_code <= wdata[17:16];
                if (wdata[31] && code_ok) begin
                    busy  <= 1'b1;
                    start <= 1'b1;
                end
            end
            if (done) begin
                busy <= 1'b0;
                if (done_rd) begin
                    cmd_data <= rd_data;
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_ADDR: rdata[3*ADR_W+DATA_W-ADR_W-1:0] = tgt;
            SEL_CMD:  rdata = {busy, 13'd0, cmd_code, cmd_data};
            SEL_MODE: rdata[NUM_C22-1:0] = mode;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
    import mdio_pkg::*;
#(
    parameter int NUM_C22 = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  target_t             tgt,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                is_read,
    input  logic [NUM_C22-1:0]  mode,
    input  logic                rise,
    input  logic                fall,
    input  logic                mdio_in,
    output logic                run,
    output logic                mdio_out,
    output logic                mdio_oe,
    output logic                done,
    output logic                done_rd,
    output logic [DATA_W-1:0]   rd_data
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_SLOTS - 1);
    localparam logic [SLOT_W-1:0] REL_SLOT  = SLOT_W'(RD_RELEASE_SLOT);
    localparam logic [SLOT_W-1:0] DAT_SLOT  = SLOT_W'(RD_DATA_SLOT);

    eng_state_e state_q, state_d;

    target_t                 tgt_q;
    logic [DATA_W-1:0]       wdat_q;
    logic                    rd_q;
    logic                    c22_q;
    logic                    phase2_q;
    logic [FRAME_SLOTS-1:0]  sh_q;
    logic [SLOT_W-1:0]       slot_q;
    logic [DATA_W-1:0]       rdsh_q;

    logic                    c22_sel;
    logic [31:0]             frame_w;
    logic                    rd_frame;
    logic                    frame_end;

    // Clause 22 selection for the port being started
    always_comb begin
        c22_sel = 1'b0;
        for (int p = 0; p < NUM_C22; p++) begin
            if (tgt.port == ADR_W'(p)) begin
                c22_sel = mode[p];
            end
        end
    end

    // Frame image after the preamble
    always_comb begin
        if (c22_q) begin
            frame_w = {2'b01, (rd_q ? 2'b10 : 2'b01), tgt_q.port,
                       tgt_q.regnum[ADR_W-1:0], 2'b10, wdat_q};
        end else if (!phase2_q) begin
            frame_w = {2'b00, 2'b00, tgt_q.port, tgt_q.dev, 2'b10, tgt_q.regnum};
        end else begin
            frame_w = {2'b00, (rd_q ? 2'b11 : 2'b01), tgt_q.port, tgt_q.dev,
                       2'b10, wdat_q};
        end
    end

    assign rd_frame  = rd_q && (c22_q || phase2_q);
    assign frame_end = fall && (slot_q == LAST_SLOT);

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_LOAD;
            ST_LOAD:  state_d = ST_SHIFT;
            ST_SHIFT: begin
                if (frame_end) begin
                    state_d = (!c22_q && !phase2_q) ? ST_LOAD : ST_DONE;
                end
            end
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q    <= '0;
            wdat_q   <= '0;
            rd_q     <= 1'b0;
            c22_q    <= 1'b0;
            phase2_q <= 1'b0;
            sh_q     <= '1;
            slot_q   <= '0;
            rdsh_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        tgt_q    <= tgt;
                        wdat_q   <= wr_data;
                        rd_q     <= is_read;
                        c22_q    <= c22_sel;
                        phase2_q <= 1'b0;
                    end
                end
                ST_LOAD: begin
                    sh_q   <= {32'hFFFF_FFFF, frame_w};
                    slot_q <= '0;
                end
                ST_SHIFT: begin
                    if (fall) begin
                        sh_q   <= {sh_q[FRAME_SLOTS-2:0], 1'b1};
                        slot_q <= slot_q + 1'b1;
                        if (slot_q == LAST_SLOT && !c22_q && !phase2_q) begin
                            phase2_q <= 1'b1;
                        end
                    end
                    if (rise && rd_frame && slot_q >= DAT_SLOT) begin
                        rdsh_q <= {rdsh_q[DATA_W-2:0], mdio_in};
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        run      = (state_q == ST_SHIFT);
        mdio_oe  = run && (!rd_frame || slot_q < REL_SLOT);
        mdio_out = mdio_oe ? sh_q[FRAME_SLOTS-1] : 1'b1;
        done     = (state_q == ST_DONE);
        done_rd  = rd_q;
        rd_data  = rdsh_q;
    end

endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
    import mdio_pkg::*;
#(
    parameter int MDC_HALF = 4,
    parameter int NUM_C22  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wen,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    input  logic        mdio_in,
    output logic        mdio_out,
    output logic        mdio_oe
);
    logic                busy_w;
    logic                start_w;
    target_t             tgt_w;
    logic [DATA_W-1:0]   cmd_data_w;
    logic [1:0]          cmd_code_w;
    logic [NUM_C22-1:0]  mode_w;
    logic                done_w;
    logic                done_rd_w;
    logic [DATA_W-1:0]   rd_data_w;
    logic                run_w;
    logic                rise_w;
    logic                fall_w;
    logic                cmd_wr_w;

    assign cmd_wr_w = reg_wen && (reg_sel == SEL_CMD);

    mdio_regs #(.NUM_C22(NUM_C22)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wen      (reg_wen),
        .sel      (reg_sel),
        .wdata    (reg_wdata),
        .done     (done_w),
        .done_rd  (done_rd_w),
        .rd_data  (rd_data_w),
        .rdata    (reg_rdata),
        .busy     (busy_w),
        .start    (start_w),
        .tgt      (tgt_w),
        .cmd_data (cmd_data_w),
        .cmd_code (cmd_code_w),
        .mode     (mode_w)
    );

    mdio_clkgen #(.MDC_HALF(MDC_HALF)) u_clk (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_w),
        .mdc   (mdc),
        .rise  (rise_w),
        .fall  (fall_w)
    );

    mdio_frame_eng #(.NUM_C22(NUM_C22)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_w),
        .tgt      (tgt_w),
        .wr_data  (cmd_data_w),
        .is_read  (cmd_code_w == CODE_RD),
        .mode     (mode_w),
        .rise     (rise_w),
        .fall     (fall_w),
        .mdio_in  (mdio_in),
        .run      (run_w),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe),
        .done     (done_w),
        .done_rd  (done_rd_w),
        .rd_data  (rd_data_w)
    );

endmodule

// File: rtl/mdio_cmd_engine_chk.sv
module mdio_cmd_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mdc,
    input logic        mdio_out,
    input logic        mdio_oe,
    input logic        busy,
    input logic        start,
    input logic        done,
    input logic        cmd_wr,
    input logic [15:0] cmd_data,
    input logic [1:0]  cmd_code
);
    AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdio_oe && !mdc)); // R10

    AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && $past(mdio_oe) && (mdio_out != $past(mdio_out)))
            |-> ($past(mdc) && !mdc)); // R10

    AST_BUSY_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R4

    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr && !done) |=> ($stable(cmd_data) && $stable(cmd_code))); // R5

    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (busy && !$past(busy))); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4

endmodule

bind mdio_cmd_engine mdio_cmd_engine_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mdc      (mdc),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe),
    .busy     (busy_w),
    .start    (start_w),
    .done     (done_w),
    .cmd_wr   (cmd_wr_w),
    .cmd_data (cmd_data_w),
    .cmd_code (cmd_code_w)
);

// File: tb/mdio_cmd_engine_tb.sv
`timescale 1ns/1ps
module mdio_cmd_engine_tb;
    localparam int HALF = 2;
    localparam int NC22 = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_in, mdio_out, mdio_oe;

    int n_chk = 0;
    int n_bad = 0;

    logic [127:0] cap = '0;
    int           ncap = 0;
    logic [15:0]  phy_val = '0;
    int           kf = 0;

    always #2.5 clk = ~clk;

    mdio_cmd_engine #(.MDC_HALF(HALF), .NUM_C22(NC22)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_in(mdio_in), .mdio_out(mdio_out), .mdio_oe(mdio_oe)
    );

    // PHY model: record driven bits, return read data
    initial mdio_in = 1'b1;
    always @(posedge mdc) begin
        #1;
        if (mdio_oe) begin
            cap  = {cap[126:0], mdio_out};
            ncap = ncap + 1;
        end
    end
    always @(negedge mdc) begin
        #1;
        if (mdio_oe) kf = 0;
        else begin
            kf = kf + 1;
            if (kf >= 3 && kf <= 18) mdio_in = phy_val[18 - kf];
            else mdio_in = 1'b1;
        end
    end

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] s, output logic [31:0] d);
        @(negedge clk);
        reg_sel = s;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        v = 32'h8000_0000;
        while (v[31]) begin
            repeat (4) @(negedge clk);
            bus_rd(2'd1, v);
        end
    endtask

    function automatic logic [127:0] exp_bits(input logic [4:0] port, input logic [15:0] rn,
                                              input logic [4:0] dev, input logic [15:0] d,
                                              input bit rd, input bit c22);
        logic [63:0] af;
        af = {32'hFFFF_FFFF, 2'b00, 2'b00, port, dev, 2'b10, rn};
        if (c22 && !rd) return {64'd0, 32'hFFFF_FFFF, 2'b01, 2'b01, port, rn[4:0], 2'b10, d};
        if (c22 &&  rd) return {82'd0, 32'hFFFF_FFFF, 2'b01, 2'b10, port, rn[4:0]};
        if (!rd)        return {af, 32'hFFFF_FFFF, 2'b00, 2'b01, port, dev, 2'b10, d};
        return {18'd0, af, 32'hFFFF_FFFF, 2'b00, 2'b11, port, dev};
    endfunction

    function automatic int exp_count(input bit rd, input bit c22);
        if (c22) return rd ? 46 : 64;
        return rd ? 110 : 128;
    endfunction

    // One full transaction with frame and readback checks (R3 R4 R6 R7 R8 R9)
    task automatic do_txn(input logic [4:0] port, input logic [15:0] rn, input logic [4:0] dev,
                          input logic [15:0] d, input bit rd, input logic [7:0] md);
        logic [31:0] v;
        bit c22;
        c22 = (port < NC22) && md[port[2:0]];
        phy_val = 16'($urandom);
        bus_wr(2'd2, {24'd0, md});
        bus_wr(2'd0, {6'd0, dev, port, rn});
        cap = '0; ncap = 0;
        bus_wr(2'd1, {1'b1, 13'd0, (rd ? 2'd3 : 2'd1), d});
        bus_rd(2'd1, v);
        check("R4 busy set", 128'(v[31]), 128'd1);
        wait_idle();
        check("R7/R8 frame count", 128'(ncap), 128'(exp_count(rd, c22)));
        check(c22 ? "R7 frame bits" : "R8 frame bits", cap, exp_bits(port, rn, dev, d, rd, c22));
        bus_rd(2'd1, v);
        if (rd) check("R9 read data", 128'(v), 128'({16'd3 , phy_val}));
        else    check("R4 write done", 128'(v), 128'({16'd1, d}));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        realtime t1, t2;
        void'($urandom(32'h5EED_0042));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_rd(2'd0, v); check("R1 target reg", 128'(v), 128'd0);
        bus_rd(2'd1, v); check("R1 command reg", 128'(v), 128'd0);
        bus_rd(2'd2, v); check("R1 mode reg", 128'(v), 128'd0);
        check("R1 pins", 128'({mdc, mdio_oe, mdio_out}), 128'(3'b001));

        // R2 field layout
        bus_wr(2'd0, 32'hFFFF_FFFF);
        bus_rd(2'd0, v); check("R2 target readback", 128'(v), 128'h03FF_FFFF);

        // R6 mode bits above the limit dropped
        bus_wr(2'd2, 32'hFFFF_FFFF);
        bus_rd(2'd2, v); check("R6 mode readback", 128'(v), 128'((1 << NC22) - 1));

        // R3 invalid codes do not start
        cap = '0; ncap = 0;
        bus_wr(2'd1, {1'b1, 13'd0, 2'd2, 16'hA5A5});
        bus_rd(2'd1, v); check("R3 code 2 no start", 128'(v), 128'h0002_A5A5);
        bus_wr(2'd1, {1'b1, 13'd0, 2'd0, 16'h1234});
        repeat (40) @(negedge clk);
        bus_rd(2'd1, v); check("R3 code 0 no start", 128'(v), 128'h0000_1234);
        check("R3 no MDC activity", 128'(ncap), 128'd0);

        // R10 MDC period and idle level
        bus_wr(2'd0, {6'd0, 5'd0, 5'd1, 16'd3});
        bus_wr(2'd1, {1'b1, 13'd0, 2'd1, 16'hBEEF});
        @(posedge mdc); t1 = $realtime;
        @(posedge mdc); t2 = $realtime;
        check("R10 MDC period", 128'(int'(t2 - t1)), 128'(2 * HALF * 5));
        wait_idle();
        check("R10 MDC low idle", 128'({mdc, mdio_oe}), 128'd0);

        // R5 write while busy ignored
        bus_wr(2'd2, 32'h0);
        bus_wr(2'd0, {6'd0, 5'd2, 5'd6, 16'h0011});
        cap = '0; ncap = 0;
        bus_wr(2'd1, {1'b1, 13'd0, 2'd1, 16'hC0DE});
        repeat (10) @(negedge clk);
        bus_wr(2'd1, {1'b1, 13'd0, 2'd3, 16'hFFFF});
        wait_idle();
        repeat (60) @(negedge clk);
        bus_rd(2'd1, v); check("R5 fields kept", 128'(v), 128'h0001_C0DE);
        check("R5 no extra frame", 128'(ncap), 128'd128);

        // Directed corners: C22 at highest allowed port, port just above limit with bit set
        do_txn(5'd3, 16'hFFFF, 5'd31, 16'h0000, 1'b0, 8'hFF); // R6 R7
        do_txn(5'd4, 16'h8001, 5'd1, 16'hFFFF, 1'b0, 8'hFF);  // R6 R8
        do_txn(5'd0, 16'h001F, 5'd0, 16'h0000, 1'b1, 8'h01);  // R9 R7
        do_txn(5'd31, 16'h4000, 5'd7, 16'h0000, 1'b1, 8'h00); // R9 R8

        // Random mix
        for (int i = 0; i < 40; i++) begin
            do_txn(5'($urandom % 8), 16'($urandom), 5'($urandom), 16'($urandom),
                   1'($urandom), 8'($urandom));
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule